// File: doc/BRIEF.md
# Configurable-Header ATM Cell Parser

This block sits behind a byte-wide receive path that already knows where each cell starts. It walks every byte of a cell and labels it as belonging to one of four fields: an optional prefix of extra header bytes used for switch-internal routing, the standard four-byte cell header, an optional header checksum octet, and the 48-byte payload. Each byte leaves the block one clock later with its data unchanged, its field tag, and markers for the first and last payload byte.

While the header passes, the block builds the 32-bit header word and runs a CRC-8 over it. When the checksum octet is enabled, the block compares it with that CRC and raises a good or a bad pulse. Two configuration inputs choose the prefix length and whether the checksum octet is present. The block samples them only on a start-of-cell byte, so the cell format cannot change partway through a cell. If a start-of-cell byte arrives before the current cell is complete, the block flags a length error and starts the new cell at that byte.

Top module: `atm_cell_parser`

## Requirements
- R1: After reset, `out_valid`, `out_pay_first`, `out_pay_last`, `out_hdr_done`, `out_hec_ok`, `out_hec_err` and `out_len_err` are all 0, and the block is outside any cell.
- R2: Each accepted byte appears on `out_data` one cycle later with `out_valid` high. Its tag on `out_tag` is 0 for prefix bytes, 1 for the four header bytes, 2 for the checksum octet and 3 for payload bytes. The fields always come in that order.
- R3: A prefix length setting of 0 gives the standard cell layout: the header first, then the checksum octet if enabled, then the payload. Settings from 13 to 15 act as 12.
- R4: A cell is prefix length + 4 + (1 if the checksum is enabled) + 48 bytes long. `out_pay_first` marks the first payload byte and `out_pay_last` marks the 48th. Bytes that arrive with `in_sop` low while the block is outside a cell are dropped: `out_valid` stays 0.
- R5: `out_hdr_done` pulses together with the output of the fourth header byte. In that same cycle `out_hdr_word` holds the header with the first header byte in bits 31:24 and the fourth in bits 7:0.
- R6: When the checksum is enabled, the expected octet is the CRC-8 of the four header bytes, XORed with 0x55. The CRC uses polynomial x^8+x^2+x+1 (0x07), an initial value of 0 and MSB-first bit order. Exactly one of `out_hec_ok` or `out_hec_err` pulses together with the checksum octet's output, and never at any other time.
- R7: When the checksum is disabled, neither `out_hec_ok` nor `out_hec_err` pulses for that cell, and the byte after the header is tagged as payload.
- R8: `cfg_ext_len` and `cfg_hec_en` are sampled only on a byte with `in_valid` and `in_sop` both high. Changing them inside a cell does not affect that cell's tags.
- R9: A start-of-cell byte that arrives while a cell is still incomplete pulses `out_len_err` together with that byte's output. That byte is then treated as byte 0 of a new cell.
- R10: A cycle with `in_valid` low gives `out_valid` low in the next cycle and does not advance the position within the cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte is present |
| in_sop | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input byte |
| cfg_ext_len | input | 4 | Prefix length in bytes (0 to 12; larger values clamp to 12) |
| cfg_hec_en | input | 1 | Checksum octet is present |
| out_valid | output | 1 | Output byte is present |
| out_data | output | 8 | Output byte |
| out_tag | output | 2 | Field tag: 0 prefix, 1 header, 2 checksum, 3 payload |
| out_pay_first | output | 1 | First payload byte |
| out_pay_last | output | 1 | 48th payload byte |
| out_hdr_word | output | 32 | Captured header, first byte in the top bits |
| out_hdr_done | output | 1 | Header word is complete this cycle |
| out_hec_ok | output | 1 | Checksum octet matched |
| out_hec_err | output | 1 | Checksum octet did not match |
| out_len_err | output | 1 | Start of cell arrived before the previous cell completed |

## Verification
If the byte position or the latched format is wrong, every later byte of the cell gets a wrong tag, so the error shows on `out_tag` one cycle after the byte that caused it. The first and last payload markers then also land on the wrong bytes. A wrong CRC state is seen only at the checksum octet, where the good and bad pulses swap. A wrong header shift register is seen only on the word that appears with `out_hdr_done`. Failing to leave the cell state after the last byte shows up two ways: a false length error on the next start-of-cell, and output on bytes that should have been dropped.

// File: rtl/atm_parse_pkg.sv
// Shared types and the header checksum step for the cell parser.
// Assumes MSB-first bit order for the CRC and an initial value of zero.
package atm_parse_pkg;

    typedef enum logic [1:0] {
        TAG_EXT = 2'd0,
        TAG_HDR = 2'd1,
        TAG_HEC = 2'd2,
        TAG_PAY = 2'd3
    } field_tag_e;

    localparam logic [7:0] HEC_POLY   = 8'h07;
    localparam logic [7:0] HEC_COSET  = 8'h55;

    // Advance a CRC-8 state by one data byte, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] state, input logic [7:0] din);
        logic [7:0] c;
        logic       fb;
        c = state;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ din[i];
            c  = {c[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
        end
        return c;
    endfunction

endpackage

// File: rtl/atm_cell_counter.sv
// Tracks the byte position within a cell and latches the cell format.
// Assumes in_sop marks byte 0 of a cell; format inputs are sampled only then.
module atm_cell_counter #(
    parameter int EXT_W     = 4,
    parameter int MAX_EXT   = 12,
    parameter int HDR_BYTES = 4,
    parameter int PAY_BYTES = 48,
    parameter int POS_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [EXT_W-1:0] cfg_ext_len,
    input  logic             cfg_hec_en,
    output logic             accept,
    output logic             early_sop,
    output logic             last_byte,
    output logic [POS_W-1:0] cur_pos,
    output logic [EXT_W-1:0] cur_ext,
    output logic             cur_hec
);

    logic             in_cell_q;
    logic [POS_W-1:0] pos_q;
    logic [EXT_W-1:0] ext_q;
    logic             hec_q;
    logic [EXT_W-1:0] cfg_clamped;
    logic [POS_W-1:0] cell_len;

    // Limit the prefix setting to its largest legal value.
    assign cfg_clamped = (cfg_ext_len > EXT_W'(MAX_EXT)) ? EXT_W'(MAX_EXT) : cfg_ext_len;

    // Select the format and position for the byte now at the input.
    always_comb begin
        cur_ext   = in_sop ? cfg_clamped : ext_q;
        cur_hec   = in_sop ? cfg_hec_en  : hec_q;
        cur_pos   = in_sop ? '0          : pos_q;
        cell_len  = POS_W'(cur_ext) + POS_W'(HDR_BYTES) + POS_W'(cur_hec) + POS_W'(PAY_BYTES);
        last_byte = (cur_pos == cell_len - POS_W'(1));
        accept    = in_valid && (in_sop || in_cell_q);
        early_sop = in_valid && in_sop && in_cell_q;
    end

    // Advance the position on every accepted byte and leave the cell after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cell_q <= 1'b0;
            pos_q     <= '0;
            ext_q     <= '0;
            hec_q     <= 1'b0;
        end else if (accept) begin
            ext_q <= cur_ext;
            hec_q <= cur_hec;
            if (last_byte) begin
                in_cell_q <= 1'b0;
                pos_q     <= '0;
            end else begin
                in_cell_q <= 1'b1;
                pos_q     <= cur_pos + POS_W'(1);
            end
        end
    end

    // R4: the stored position stays inside the latched cell length.
    p_pos_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_cell_q |-> (pos_q < POS_W'(ext_q) + POS_W'(HDR_BYTES) + POS_W'(hec_q) + POS_W'(PAY_BYTES)));

    // R8: the latched format holds inside a cell unless a new cell starts.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cell_q && !(in_valid && in_sop)) |=> ($stable(ext_q) && $stable(hec_q)));

endmodule

// File: rtl/atm_field_tagger.sv
// Maps a byte position and cell format to a field tag and payload markers.
// Purely combinational; assumes the position is already relative to byte 0.
module atm_field_tagger
    import atm_parse_pkg::*;
#(
    parameter int EXT_W     = 4,
    parameter int HDR_BYTES = 4,
    parameter int PAY_BYTES = 48,
    parameter int POS_W     = 7
) (
    input  logic [POS_W-1:0] pos,
    input  logic [EXT_W-1:0] ext_len,
    input  logic             hec_en,
    output field_tag_e       tag,
    output logic             hdr_last,
    output logic             pay_first,
    output logic             pay_last
);

    logic [POS_W-1:0] hdr_end;
    logic [POS_W-1:0] pay_start;

    // Decode the field boundaries from the prefix length and checksum option.
    always_comb begin
        hdr_end   = POS_W'(ext_len) + POS_W'(HDR_BYTES);
        pay_start = hdr_end + POS_W'(hec_en);
        if (pos < POS_W'(ext_len))      tag = TAG_EXT;
        else if (pos < hdr_end)         tag = TAG_HDR;
        else if (pos < pay_start)       tag = TAG_HEC;
        else                            tag = TAG_PAY;
        hdr_last  = (pos == hdr_end - POS_W'(1));
        pay_first = (pos == pay_start);
        pay_last  = (pos == pay_start + POS_W'(PAY_BYTES - 1));
    end

endmodule

// File: rtl/atm_hdr_check.sv
// Captures the header word and verifies the checksum octet against its CRC.
// Assumes header bytes arrive in order and the checksum octet follows them.
module atm_hdr_check
    import atm_parse_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic        in_sop,
    input  field_tag_e  tag,
    input  logic        hdr_last,
    input  logic [7:0]  data,
    output logic [31:0] hdr_word,
    output logic        hdr_done,
    output logic        hec_ok,
    output logic        hec_err
);

    logic [7:0] crc_q;
    logic [7:0] crc_base;

    // Start from zero at each new cell.
    assign crc_base = in_sop ? 8'h00 : crc_q;

    // Shift header bytes into the word and fold them into the CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q    <= 8'h00;
            hdr_word <= '0;
            hdr_done <= 1'b0;
        end else begin
            hdr_done <= accept && (tag == TAG_HDR) && hdr_last;
            if (accept && tag == TAG_HDR) begin
                crc_q    <= crc8_step(crc_base, data);
                hdr_word <= {hdr_word[23:0], data};
            end else if (accept && in_sop) begin
                crc_q <= 8'h00;
            end
        end
    end

    // Compare the checksum octet with the finished CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hec_ok  <= 1'b0;
            hec_err <= 1'b0;
        end else begin
            hec_ok  <= accept && (tag == TAG_HEC) && (data == (crc_q ^ HEC_COSET));
            hec_err <= accept && (tag == TAG_HEC) && (data != (crc_q ^ HEC_COSET));
        end
    end

    // R6: a checksum verdict is never both good and bad.
    p_hec_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hec_ok && hec_err));

endmodule

// File: rtl/atm_cell_parser.sv
// Top level: splits a byte stream of cells into tagged fields with one cycle of latency.
// Assumes an upstream stage has already found the cell boundaries and marks byte 0 with in_sop.
module atm_cell_parser
    import atm_parse_pkg::*;
#(
    parameter int EXT_W     = 4,
    parameter int MAX_EXT   = 12,
    parameter int HDR_BYTES = 4,
    parameter int PAY_BYTES = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic [EXT_W-1:0] cfg_ext_len,
    input  logic             cfg_hec_en,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic [1:0]       out_tag,
    output logic             out_pay_first,
    output logic             out_pay_last,
    output logic [31:0]      out_hdr_word,
    output logic             out_hdr_done,
    output logic             out_hec_ok,
    output logic             out_hec_err,
    output logic             out_len_err
);

    localparam int MAX_CELL = MAX_EXT + HDR_BYTES + 1 + PAY_BYTES;
    localparam int POS_W    = $clog2(MAX_CELL + 1);

    logic             accept;
    logic             early_sop;
    logic             last_byte;
    logic [POS_W-1:0] cur_pos;
    logic [EXT_W-1:0] cur_ext;
    logic             cur_hec;
    field_tag_e       tag;
    logic             hdr_last;
    logic             pay_first;
    logic             pay_last;

    atm_cell_counter #(
        .EXT_W(EXT_W), .MAX_EXT(MAX_EXT), .HDR_BYTES(HDR_BYTES),
        .PAY_BYTES(PAY_BYTES), .POS_W(POS_W)
    ) u_counter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .cfg_ext_len(cfg_ext_len), .cfg_hec_en(cfg_hec_en),
        .accept(accept), .early_sop(early_sop), .last_byte(last_byte),
        .cur_pos(cur_pos), .cur_ext(cur_ext), .cur_hec(cur_hec)
    );

    atm_field_tagger #(
        .EXT_W(EXT_W), .HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES), .POS_W(POS_W)
    ) u_tagger (
        .pos(cur_pos), .ext_len(cur_ext), .hec_en(cur_hec),
        .tag(tag), .hdr_last(hdr_last), .pay_first(pay_first), .pay_last(pay_last)
    );

    atm_hdr_check u_hdr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .in_sop(in_sop),
        .tag(tag), .hdr_last(hdr_last), .data(in_data),
        .hdr_word(out_hdr_word), .hdr_done(out_hdr_done),
        .hec_ok(out_hec_ok), .hec_err(out_hec_err)
    );

    // Register the byte, its tag and the markers for output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_data      <= 8'h00;
            out_tag       <= 2'd0;
            out_pay_first <= 1'b0;
            out_pay_last  <= 1'b0;
            out_len_err   <= 1'b0;
        end else begin
            out_valid     <= accept;
            out_data      <= in_data;
            out_tag       <= tag;
            out_pay_first <= accept && pay_first;
            out_pay_last  <= accept && pay_last && last_byte;
            out_len_err   <= early_sop;
        end
    end

    // R4: payload markers appear only on payload-tagged output bytes.
    p_mark_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pay_first || out_pay_last) |-> (out_valid && out_tag == 2'd3));

    // R6: a checksum verdict comes only with the checksum octet.
    p_hec_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hec_ok || out_hec_err) |-> (out_valid && out_tag == 2'd2));

    // R10: an idle input cycle produces no output byte next cycle.
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

endmodule

// File: tb/atm_cell_parser_bench.sv
`timescale 1ns/1ps
// Directed bench for the cell parser: one task per scenario, each checking its own outputs.
module atm_cell_parser_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic [3:0]  cfg_ext_len = 4'd0;
    logic        cfg_hec_en = 1'b1;
    logic        out_valid, out_pay_first, out_pay_last, out_hdr_done;
    logic        out_hec_ok, out_hec_err, out_len_err;
    logic [7:0]  out_data;
    logic [1:0]  out_tag;
    logic [31:0] out_hdr_word;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    atm_cell_parser u_atm_cell_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .cfg_ext_len(cfg_ext_len), .cfg_hec_en(cfg_hec_en),
        .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag),
        .out_pay_first(out_pay_first), .out_pay_last(out_pay_last),
        .out_hdr_word(out_hdr_word), .out_hdr_done(out_hdr_done),
        .out_hec_ok(out_hec_ok), .out_hec_err(out_hec_err), .out_len_err(out_len_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference header checksum: bit-serial CRC-8, poly 0x07, over a 32-bit word.
    function automatic logic [7:0] ref_hec(input logic [31:0] w);
        logic [7:0] r = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            if (r[7] ^ w[i]) r = (r << 1) ^ 8'h07;
            else             r = r << 1;
        end
        return r ^ 8'h55;
    endfunction

    // Send one cell (possibly truncated) and check every output byte one cycle later.
    // gap_at: byte index before which an idle cycle is inserted (-1 for none).
    task automatic send_cell(input logic [3:0] cfg_e, input bit hec, input int nbytes,
                             input bit corrupt, input bit mid_change, input int gap_at,
                             input bit exp_len_err, input logic [7:0] seed, input string treq);
        int e = (cfg_e > 4'd12) ? 12 : int'(cfg_e);
        int h = hec ? 1 : 0;
        logic [31:0] hw;
        logic [7:0] bytes [0:64];
        int last_k = -1;
        for (int k = 0; k < 65; k++) bytes[k] = seed + 8'(k * 3);
        hw = {bytes[e], bytes[e+1], bytes[e+2], bytes[e+3]};
        if (hec) bytes[e+4] = ref_hec(hw) ^ (corrupt ? 8'h01 : 8'h00);
        cfg_ext_len = cfg_e;
        cfg_hec_en  = hec;
        for (int k = 0; k <= nbytes; k++) begin
            @(negedge clk);
            if (last_k >= 0) begin
                int p = last_k;
                logic [1:0] et;
                if (p < e)                 et = 2'd0;
                else if (p < e + 4)        et = 2'd1;
                else if (h == 1 && p == e + 4) et = 2'd2;
                else                       et = 2'd3;
                chk(out_valid == 1'b1, "R2", "out_valid", 32'(out_valid), 1);
                chk(out_data == bytes[p], "R2", "out_data", 32'(out_data), 32'(bytes[p]));
                chk(out_tag == et, treq, "out_tag", 32'(out_tag), 32'(et));
                chk(out_pay_first == (p == e + 4 + h), "R4", "pay_first",
                    32'(out_pay_first), 32'(p == e + 4 + h));
                chk(out_pay_last == (p == e + 4 + h + 47), "R4", "pay_last",
                    32'(out_pay_last), 32'(p == e + 4 + h + 47));
                chk(out_hdr_done == (p == e + 3), "R5", "hdr_done",
                    32'(out_hdr_done), 32'(p == e + 3));
                if (p == e + 3) chk(out_hdr_word == hw, "R5", "hdr_word", out_hdr_word, hw);
                if (hec) begin
                    chk(out_hec_ok == (p == e + 4 && !corrupt), "R6", "hec_ok",
                        32'(out_hec_ok), 32'(p == e + 4 && !corrupt));
                    chk(out_hec_err == (p == e + 4 && corrupt), "R6", "hec_err",
                        32'(out_hec_err), 32'(p == e + 4 && corrupt));
                end else begin
                    chk(!out_hec_ok && !out_hec_err, "R7", "hec pulses",
                        32'({out_hec_ok, out_hec_err}), 0);
                end
                chk(out_len_err == (p == 0 && exp_len_err), "R9", "len_err",
                    32'(out_len_err), 32'(p == 0 && exp_len_err));
            end else if (k > 0) begin
                chk(out_valid == 1'b0, "R10", "idle out_valid", 32'(out_valid), 0);
            end
            if (k == 3 && mid_change) begin
                cfg_ext_len = (cfg_e == 4'd5) ? 4'd1 : 4'd5;
                cfg_hec_en  = ~hec;
            end
            last_k = -1;
            if (k == nbytes) begin
                in_valid = 1'b0;
                in_sop   = 1'b0;
            end else if (k == gap_at) begin
                in_valid = 1'b0;
                in_sop   = 1'b0;
                gap_at   = -1;
                k--;
            end else begin
                in_valid = 1'b1;
                in_sop   = (k == 0);
                in_data  = bytes[k];
                last_k   = k;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_pay_first && !out_pay_last && !out_hdr_done
            && !out_hec_ok && !out_hec_err && !out_len_err, "R1", "reset outputs",
            32'({out_valid, out_pay_first, out_pay_last, out_hdr_done,
                 out_hec_ok, out_hec_err, out_len_err}), 0);
    endtask

    // Bytes without in_sop after a finished cell are dropped (R4).
    task automatic t_ignore();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (i > 0) chk(out_valid == 1'b0, "R4", "stray byte out_valid", 32'(out_valid), 0);
            in_valid = 1'b1;
            in_sop   = 1'b0;
            in_data  = 8'hA5;
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R4", "stray byte out_valid", 32'(out_valid), 0);
        in_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        // standard cell with a good checksum
        send_cell(4'd0, 1'b1, 53, 1'b0, 1'b0, -1, 1'b0, 8'h10, "R3");
        // standard cell with a corrupted checksum
        send_cell(4'd0, 1'b1, 53, 1'b1, 1'b0, -1, 1'b0, 8'h40, "R2");
        // largest prefix, no checksum
        send_cell(4'd12, 1'b0, 64, 1'b0, 1'b0, -1, 1'b0, 8'h07, "R2");
        // out-of-range prefix setting clamps to 12
        send_cell(4'd15, 1'b1, 65, 1'b0, 1'b0, -1, 1'b0, 8'h33, "R3");
        // prefix 3 with checksum, configuration changed mid-cell
        send_cell(4'd3, 1'b1, 56, 1'b0, 1'b1, -1, 1'b0, 8'h91, "R8");
        // idle cycle inside the header
        send_cell(4'd2, 1'b1, 55, 1'b0, 1'b0, 4, 1'b0, 8'h5C, "R10");
        t_ignore();
        // truncated cell, then an early start of cell
        send_cell(4'd1, 1'b0, 20, 1'b0, 1'b0, -1, 1'b0, 8'h22, "R2");
        send_cell(4'd1, 1'b1, 54, 1'b0, 1'b0, -1, 1'b1, 8'hC8, "R9");
        // next cell after a complete one carries no length error
        send_cell(4'd0, 1'b0, 52, 1'b0, 1'b0, -1, 1'b0, 8'hE1, "R9");
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule